// File: doc/BRIEF.md
# Data-Space Address Decoder

This block sits between the load/store units of a small processor core and the storage behind them. It takes an access address and decides which of four regions it lands in: the 32-entry register file, the 64-location standard I/O block, the extended I/O block, or general SRAM. It returns a one-hot region select and the offset of the access inside the chosen region. The whole path is combinational, so the result is valid in the same cycle as the address.

The standard I/O block is visible in two ways. Load and store instructions see it as ordinary data addresses just past the register file. The short I/O instructions carry a small port number instead, and the decoder turns it into the matching data address by adding the size of the register file. The stack pointer and other core control registers live in this block and are reached the same way. Extended I/O can only be reached through load and store instructions. A port number that points past the standard block is flagged as an illegal access. An address above the configured top of SRAM is flagged as out of range.

Top module: `dsdec_top`

## Requirements
- R1: In load/store mode (`ioMode`=0), addresses 0x0000 to 0x001F assert `regionSel`=4'b0001 (register file) and `regionOffset` equals the address.
- R2: In load/store mode, addresses 0x0020 to 0x005F assert `regionSel`=4'b0010 (standard I/O) and `regionOffset` equals the address minus 0x20.
- R3: In load/store mode, addresses 0x0060 to 0x00FF assert `regionSel`=4'b0100 (extended I/O) and `regionOffset` equals the address minus 0x60.
- R4: In load/store mode, addresses from 0x0100 up to and including `SRAM_TOP` (default 0x08FF) assert `regionSel`=4'b1000 (SRAM) and `regionOffset` equals the address minus 0x100.
- R5: An address above `SRAM_TOP` asserts `outOfRange`, drives `regionSel` to zero and `regionOffset` to zero.
- R6: In I/O mode (`ioMode`=1) with `ioAddr` from 0 to 63, `dataAddr` equals `ioAddr`+0x20, `regionSel`=4'b0010 and `regionOffset` equals `ioAddr`; `accAddr` has no effect.
- R7: In I/O mode with `ioAddr` of 64 or more, `illegalAccess` is asserted, `regionSel` and `regionOffset` are zero, and `outOfRange` is low.
- R8: In load/store mode `dataAddr` equals `accAddr`, `ioAddr` has no effect, and `illegalAccess` is low.
- R9: For every input, exactly one of the four select bits, `outOfRange` and `illegalAccess` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| accAddr | input | 16 | Data-space address from a load/store instruction |
| ioMode | input | 1 | 1 = short I/O instruction, 0 = load/store |
| ioAddr | input | 8 | Port number carried by an I/O instruction |
| regionSel | output | 4 | One-hot region: bit0 regfile, bit1 std I/O, bit2 ext I/O, bit3 SRAM |
| regionOffset | output | 16 | Offset inside the selected region |
| dataAddr | output | 16 | Effective data-space address after translation |
| outOfRange | output | 1 | Address lies above the SRAM top |
| illegalAccess | output | 1 | I/O instruction addressed outside the standard block |

## Verification
The hardest situations are the region edges and the I/O-mode cases whose port number would translate into extended I/O: a plain address sweep almost never lands on 0x5F/0x60, 0xFF/0x100 or one past the SRAM top, and random 16-bit addresses are mostly out of range. The stimulus therefore chooses a region first and then an address near either of its edges, mixes in I/O-mode accesses with port numbers on both sides of 63 while `accAddr` holds unrelated values, and adds directed vectors on every edge. Each result is checked against a reference function written from the requirements.

// File: rtl/dsdec_pkg.sv
package dsdec_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic hitReg;
    logic hitStd;
    logic hitExt;
    logic hitSram;
    logic oor;
    logic illegal;
  } decStrobes_t;

  localparam int RGN_N = 4;
endpackage

// File: rtl/dsdec_ctrl.sv
module dsdec_ctrl
  import dsdec_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int IO_W     = 8,
  parameter int REG_N    = 32,
  parameter int IO_N     = 64,
  parameter int EXT_END  = 256,
  parameter int SRAM_TOP = 16'h08FF
) (
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic              ioMode,
  input  logic [IO_W-1:0]   ioAddr,
  output decStrobes_t       stb
);
  localparam logic [ADDR_W-1:0] STD_BASE  = ADDR_W'(REG_N);
  localparam logic [ADDR_W-1:0] EXT_BASE  = ADDR_W'(REG_N + IO_N);
  localparam logic [ADDR_W-1:0] SRAM_BASE = ADDR_W'(EXT_END);
  localparam logic [ADDR_W-1:0] TOP_A     = ADDR_W'(SRAM_TOP);
  localparam logic [ADDR_W-1:0] IO_LIM    = ADDR_W'(IO_N);

  logic ioBad;
  assign ioBad = ioMode && (ADDR_W'(ioAddr) >= IO_LIM);

  always_comb begin
    stb = '0;
    if (ioBad)                  stb.illegal = 1'b1;
    else if (dataAddr < STD_BASE)  stb.hitReg  = 1'b1;
    else if (dataAddr < EXT_BASE)  stb.hitStd  = 1'b1;
    else if (dataAddr < SRAM_BASE) stb.hitExt  = 1'b1;
    else if (dataAddr <= TOP_A)    stb.hitSram = 1'b1;
    else                           stb.oor     = 1'b1;
  end

  always_comb begin
    // R9
    one_outcome_chk: assert ($countones(stb) == 1);
    // R7
    illegal_only_io_chk: assert (!stb.illegal || ioMode);
    // R3
    ext_not_io_chk: assert (!(stb.hitExt && ioMode));
  end
endmodule

// File: rtl/dsdec_path.sv
module dsdec_path
  import dsdec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IO_W    = 8,
  parameter int REG_N   = 32,
  parameter int IO_N    = 64,
  parameter int EXT_END = 256
) (
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              ioMode,
  input  logic [IO_W-1:0]   ioAddr,
  input  decStrobes_t       stb,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [RGN_N-1:0]  regionSel,
  output logic [ADDR_W-1:0] regionOffset
);
  localparam logic [ADDR_W-1:0] STD_BASE  = ADDR_W'(REG_N);
  localparam logic [ADDR_W-1:0] EXT_BASE  = ADDR_W'(REG_N + IO_N);
  localparam logic [ADDR_W-1:0] SRAM_BASE = ADDR_W'(EXT_END);

  // I/O port numbers sit just past the register file in data space
  assign dataAddr  = ioMode ? (ADDR_W'(ioAddr) + STD_BASE) : accAddr;
  assign regionSel = {stb.hitSram, stb.hitExt, stb.hitStd, stb.hitReg};

  always_comb begin
    regionOffset = '0;
    if (stb.hitReg)       regionOffset = dataAddr;
    else if (stb.hitStd)  regionOffset = dataAddr - STD_BASE;
    else if (stb.hitExt)  regionOffset = dataAddr - EXT_BASE;
    else if (stb.hitSram) regionOffset = dataAddr - SRAM_BASE;
  end

  always_comb begin
    // R1
    reg_offset_bound_chk: assert (!regionSel[0] || regionOffset < STD_BASE);
    // R2
    std_offset_bound_chk: assert (!regionSel[1] || regionOffset < ADDR_W'(IO_N));
    // R6
    io_lands_std_chk: assert (!(ioMode && !stb.illegal) || regionSel == 4'b0010);
    // R5
    none_zero_offset_chk: assert (regionSel != '0 || regionOffset == '0);
  end
endmodule

// File: rtl/dsdec_top.sv
module dsdec_top
  import dsdec_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int IO_W     = 8,
  parameter int REG_N    = 32,
  parameter int IO_N     = 64,
  parameter int EXT_END  = 256,
  parameter int SRAM_TOP = 16'h08FF
) (
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              ioMode,
  input  logic [IO_W-1:0]   ioAddr,
  output logic [3:0]        regionSel,
  output logic [ADDR_W-1:0] regionOffset,
  output logic [ADDR_W-1:0] dataAddr,
  output logic              outOfRange,
  output logic              illegalAccess
);
  decStrobes_t stb;

  dsdec_path #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .REG_N(REG_N), .IO_N(IO_N), .EXT_END(EXT_END)
  ) uPath (
    .accAddr(accAddr), .ioMode(ioMode), .ioAddr(ioAddr), .stb(stb),
    .dataAddr(dataAddr), .regionSel(regionSel), .regionOffset(regionOffset)
  );

  dsdec_ctrl #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .REG_N(REG_N), .IO_N(IO_N),
    .EXT_END(EXT_END), .SRAM_TOP(SRAM_TOP)
  ) uCtrl (
    .dataAddr(dataAddr), .ioMode(ioMode), .ioAddr(ioAddr), .stb(stb)
  );

  assign outOfRange    = stb.oor;
  assign illegalAccess = stb.illegal;
endmodule

// File: tb/dsdec_top_test.sv
module dsdec_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] accAddr = '0;
  logic        ioMode = 1'b0;
  logic [7:0]  ioAddr = '0;
  logic [3:0]  regionSel;
  logic [15:0] regionOffset, dataAddr;
  logic        outOfRange, illegalAccess;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam int TOP = 16'h08FF;

  always #4 clk = ~clk;

  dsdec_top uut (
    .accAddr(accAddr), .ioMode(ioMode), .ioAddr(ioAddr),
    .regionSel(regionSel), .regionOffset(regionOffset), .dataAddr(dataAddr),
    .outOfRange(outOfRange), .illegalAccess(illegalAccess)
  );

  // Reference model from the requirements
  task automatic expect_of(input logic [15:0] a, input logic m, input logic [7:0] p,
                           output logic [3:0] s, output logic [15:0] off,
                           output logic [15:0] da, output logic oor,
                           output logic ill, output string tag);
    int ea;
    s = 4'b0; off = '0; oor = 0; ill = 0;
    if (m) begin
      da = 16'(p) + 16'h20;
      if (p >= 8'd64) begin ill = 1; tag = "R7"; return; end
      s = 4'b0010; off = 16'(p); tag = "R6"; return;
    end
    da = a; ea = int'(a);
    if (ea < 32)       begin s = 4'b0001; off = a;            tag = "R1"; end
    else if (ea < 96)  begin s = 4'b0010; off = a - 16'h20;   tag = "R2"; end
    else if (ea < 256) begin s = 4'b0100; off = a - 16'h60;   tag = "R3"; end
    else if (ea <= TOP) begin s = 4'b1000; off = a - 16'h100; tag = "R4"; end
    else begin oor = 1; tag = "R5"; end
  endtask

  task automatic apply(input logic [15:0] a, input logic m, input logic [7:0] p);
    logic [3:0] s; logic [15:0] off, da; logic oor, ill; string tag;
    @(posedge clk);
    accAddr = a; ioMode = m; ioAddr = p;
    @(negedge clk);
    expect_of(a, m, p, s, off, da, oor, ill, tag);
    total++;
    if (regionSel !== s || regionOffset !== off || dataAddr !== da ||
        outOfRange !== oor || illegalAccess !== ill) begin
      bad++;
      $display("FAIL %s (R8/R9 also) a=%h m=%0d p=%h: got sel=%b off=%h da=%h oor=%b ill=%b exp sel=%b off=%h da=%h oor=%b ill=%b",
               tag, a, m, p, regionSel, regionOffset, dataAddr, outOfRange, illegalAccess,
               s, off, da, oor, ill);
    end
    // R9: exactly one outcome
    total++;
    if ($countones({regionSel, outOfRange, illegalAccess}) != 1) begin
      bad++;
      $display("FAIL R9 outcome count got=%0d exp=1",
               $countones({regionSel, outOfRange, illegalAccess}));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: inputs zero -> register file, offset 0
    total++;
    if (regionSel !== 4'b0001 || regionOffset !== 16'h0) begin
      bad++;
      $display("FAIL R1 reset state got sel=%b off=%h exp sel=0001 off=0000", regionSel, regionOffset);
    end
    // Directed edges: R1 R2 R3 R4 R5
    apply(16'h0000, 0, 8'hAA); apply(16'h001F, 0, 8'h00);
    apply(16'h0020, 0, 8'hFF); apply(16'h005F, 0, 8'h10);
    apply(16'h0060, 0, 8'h40); apply(16'h00FF, 0, 8'h3F);
    apply(16'h0100, 0, 8'h00); apply(16'(TOP), 0, 8'h00);
    apply(16'(TOP + 1), 0, 8'h00); apply(16'hFFFF, 0, 8'h00);
    // R6 R7: I/O mode edges, accAddr unrelated (R8 ioAddr ignored above)
    apply(16'hFFFF, 1, 8'd0);  apply(16'h0150, 1, 8'd63);
    apply(16'h0000, 1, 8'd64); apply(16'h0070, 1, 8'd255);
    apply(16'h0030, 1, 8'd61);
    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      int r; logic [15:0] a; logic [7:0] p; logic m;
      r = int'($urandom % 6);
      m = ($urandom % 4) == 0;
      p = ($urandom % 2) ? 8'($urandom % 72) : 8'($urandom);
      case (r)
        0: a = 16'($urandom % 40);
        1: a = 16'(28 + $urandom % 72);
        2: a = 16'(92 + $urandom % 168);
        3: a = 16'(250 + $urandom % 20);
        4: a = 16'(TOP - 8 + $urandom % 16);
        default: a = 16'($urandom);
      endcase
      apply(a, m, p);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule